// File: doc/BRIEF.md
# Paging Frame Timing Sequencer

This block turns an oversampled stream of four-level receive symbols into the timing of one paging frame. Every input sample carries a two-bit symbol code together with a flag from an external correlator that says whether the frame sync pattern currently matches. The block keeps a slot counter that runs over the samples of one baud. It measures how long the sync match persists and takes the middle of that run as the bit centre. From then on it samples the symbol stream only at that centre slot.

After sync, the block shifts in a preamble of dotting bits followed by the 32-bit frame information word. It then latches the data-rate mode supplied alongside the sync match and skips the second sync period. At the higher rate it rescales its sample grid. For the data portion it emits one strobe per centre symbol and then returns to idle, ready for the next frame. Error correction and the meaning of the information word belong to downstream logic.

Top module: `pager_frame_seq`

## Requirements
- R1: After reset the block is idle. `frame_busy`, `fiw_valid`, `data_strobe` and `frame_end` are low, and the current mode reads 1600 baud with two levels (`cur_baud_hi`=0, `cur_four_lvl`=0).
- R2: A slot index starts at 0 and advances by one on each cycle with `sample_vld` high, wrapping to 0 when it reaches the samples per baud (10 at 1600 baud, 5 at 3200 baud). It holds while `sample_vld` is low.
- R3: In idle, a sample with `sync_hit` high starts a sync run and records its slot as the start. The first later sample with `sync_hit` low ends the run and records its slot as the stop. The centre is (start+stop)/2 when start < stop, and ((start+stop)/2 + spb/2) mod spb otherwise, using integer division and spb = 10.
- R4: After the sync run, only samples whose slot equals the centre are used. Each contributes bit 1 for symbol codes 2 and 3 and bit 0 for codes 0 and 1, shifted in oldest first. Samples at other slots and `sync_hit` have no effect.
- R5: On the 48th centre bit, the 32 most recent bits appear on `fiw_word` (the last bit at bit 0) with `fiw_valid` high for exactly one cycle, in the cycle after that sample.
- R6: At that 48th bit, `mode_baud_hi` (1 = 3200 baud) and `mode_four_lvl` are latched onto `cur_baud_hi` and `cur_four_lvl` and stay fixed until the frame ends. At 3200 baud, the centre is halved, the slot becomes slot/2 − 2 (it may go negative and counts up to 0 before wrapping again), and spb becomes 5.
- R7: The gap after the information word spans 40 centre samples at 1600 baud and 81 at 3200 baud (its counter starts at −1). The next centre sample is the first data symbol.
- R8: In the data portion, each centre sample raises `data_strobe` for one cycle with the raw code on `data_symbol`. There are exactly 2816 strobes at 1600 baud and 5632 at 3200 baud.
- R9: `frame_end` pulses in the same cycle as the last data strobe. The block is then idle with the mode back at 1600 baud and two levels, and its slot is back at 0. A `sync_hit` on that last data sample does not start a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | One oversampled symbol present this cycle |
| rx_symbol | input | 2 | Sliced symbol code 0..3 |
| sync_hit | input | 1 | Correlator reports a sync match on this sample |
| mode_baud_hi | input | 1 | Matched mode uses 3200 baud for the rest of the frame |
| mode_four_lvl | input | 1 | Matched mode uses four-level symbols |
| frame_busy | output | 1 | Any state other than idle |
| cur_baud_hi | output | 1 | Latched rate of the current frame |
| cur_four_lvl | output | 1 | Latched level count of the current frame |
| fiw_word | output | 32 | Collected frame information word |
| fiw_valid | output | 1 | One-cycle pulse when `fiw_word` is fresh |
| data_strobe | output | 1 | One-cycle pulse per data symbol |
| data_symbol | output | 2 | Symbol code accompanying `data_strobe` |
| frame_end | output | 1 | One-cycle pulse on the return to idle |

## Verification
Two events can fall in one cycle: the final data strobe and the return to idle, which also resets the mode and the slot grid. The bench raises `sync_hit` on exactly that last centre sample. Its scoreboard expects the data item and then the end item from the same cycle, with no further activity. A follow-up frame whose expected centre assumes a slot restart at 0 confirms the grid reset. A 3200-baud frame whose centre wraps to slot 0 forces the rescaled slot negative. Another frame has stall cycles interleaved, which shows that the grid counts samples rather than clocks.

// File: rtl/pfs_pkg.sv
// Package: shared state encoding for the paging frame sequencer.
// Assumes: used by pager_frame_seq only.
package pfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNCING = 3'd1,
        ST_SYNC1   = 3'd2,
        ST_SYNC2   = 3'd3,
        ST_DATA    = 3'd4
    } pfs_state_e;
endpackage

// File: rtl/pfs_slot_ctr.sv
// Module: pfs_slot_ctr
// Counts the sample slot inside one baud. Advances on each valid sample and
// wraps at spb. It can be cleared or loaded (with a possibly negative value)
// on a valid sample. Assumes spb > 0 and any loaded value lies in (-spb, spb).
module pfs_slot_ctr #(
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 clr,
    input  logic                 ld,
    input  logic signed [IW-1:0] spb,
    input  logic signed [IW-1:0] ld_val,
    output logic signed [IW-1:0] idx_q,
    output logic signed [IW-1:0] idx_adv
);
    localparam logic signed [IW-1:0] ONE = IW'(1);

    logic signed [IW-1:0] idx_inc;

    // Next slot value if this sample advances the grid
    assign idx_inc = idx_q + ONE;
    assign idx_adv = (idx_inc == spb) ? '0 : idx_inc;

    // Slot register: clear, load or advance on a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (adv) begin
            if (clr)
                idx_q <= '0;
            else if (ld)
                idx_q <= ld_val;
            else
                idx_q <= idx_adv;
        end
    end

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q < spb) && (idx_q > -spb));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx_q));
endmodule

// File: rtl/pfs_centre_calc.sv
// Module: pfs_centre_calc
// Combinational modulo midpoint of a sync run on the slot circle.
// Assumes both slots lie in [0, spb).
module pfs_centre_calc #(
    parameter int IW = 5
) (
    input  logic signed [IW-1:0] first_slot,
    input  logic signed [IW-1:0] last_slot,
    input  logic signed [IW-1:0] spb,
    output logic signed [IW-1:0] centre
);
    logic signed [IW:0] sum_w;
    logic signed [IW:0] half_w;
    logic signed [IW:0] shifted_w;
    logic signed [IW:0] spb_w;

    // Midpoint directly, or shifted by half a baud and wrapped when the run crosses slot 0
    always_comb begin
        spb_w     = {spb[IW-1], spb};
        sum_w     = {first_slot[IW-1], first_slot} + {last_slot[IW-1], last_slot};
        half_w    = sum_w >>> 1;
        shifted_w = half_w + (spb_w >>> 1);
        if (shifted_w >= spb_w)
            shifted_w = shifted_w - spb_w;
        if (first_slot < last_slot)
            centre = half_w[IW-1:0];
        else
            centre = shifted_w[IW-1:0];
    end
endmodule

// File: rtl/pager_frame_seq.sv
// Module: pager_frame_seq (top)
// Sequences one paging frame: sync run, centre estimate, 48 centre bits
// (dotting plus information word), mode latch with 3200-baud grid rescale,
// gap skip, then one strobe per data symbol before returning to idle.
// Assumes sync_hit and mode inputs come from an external correlator, and
// the mode inputs are valid at the last information-word bit.
module pager_frame_seq #(
    parameter int SPB_LO    = 10,
    parameter int SPB_HI    = 5,
    parameter int LEAD_BITS = 48,
    parameter int FIW_W     = 32,
    parameter int GAP_LO    = 40,
    parameter int GAP_HI    = 80,
    parameter int DATA_LO   = 2816,
    parameter int DATA_HI   = 5632
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [1:0]       rx_symbol,
    input  logic             sync_hit,
    input  logic             mode_baud_hi,
    input  logic             mode_four_lvl,
    output logic             frame_busy,
    output logic             cur_baud_hi,
    output logic             cur_four_lvl,
    output logic [FIW_W-1:0] fiw_word,
    output logic             fiw_valid,
    output logic             data_strobe,
    output logic [1:0]       data_symbol,
    output logic             frame_end
);
    import pfs_pkg::*;

    localparam int IW = $clog2(SPB_LO + 1) + 1;
    localparam int CW = $clog2(DATA_HI + 1) + 2;
    localparam logic signed [IW-1:0] SPB_LO_S  = IW'(SPB_LO);
    localparam logic signed [IW-1:0] SPB_HI_S  = IW'(SPB_HI);
    localparam logic signed [IW-1:0] HALF_HI_S = IW'(SPB_HI / 2);
    localparam logic signed [CW-1:0] LEAD_S    = CW'(LEAD_BITS);
    localparam logic signed [CW-1:0] GAP_LO_S  = CW'(GAP_LO);
    localparam logic signed [CW-1:0] GAP_HI_S  = CW'(GAP_HI);
    localparam logic signed [CW-1:0] DATA_LO_S = CW'(DATA_LO);
    localparam logic signed [CW-1:0] DATA_HI_S = CW'(DATA_HI);
    localparam logic signed [CW-1:0] ONE_C     = CW'(1);
    localparam logic signed [CW-1:0] MINUS_ONE = -ONE_C;

    pfs_state_e           state;
    logic signed [IW-1:0] start_q, centre_q, centre_w;
    logic signed [IW-1:0] idx_q, idx_adv, spb_cur, ld_val;
    logic signed [CW-1:0] count_q, cnt_inc, gap_lim, data_lim;
    logic [FIW_W-1:0]     fiw_sr;
    logic                 at_centre, new_bit, go_sync2, end_data;

    // Rate-dependent constants for the current frame
    assign spb_cur  = cur_baud_hi ? SPB_HI_S : SPB_LO_S;
    assign gap_lim  = cur_baud_hi ? GAP_HI_S : GAP_LO_S;
    assign data_lim = cur_baud_hi ? DATA_HI_S : DATA_LO_S;

    // Per-sample decode of centre hits and state exits
    assign at_centre  = sample_vld && (idx_adv == centre_q);
    assign cnt_inc    = count_q + ONE_C;
    assign new_bit    = rx_symbol[1];
    assign go_sync2   = (state == ST_SYNC1) && at_centre && (cnt_inc == LEAD_S);
    assign end_data   = (state == ST_DATA) && at_centre && (cnt_inc == data_lim);
    assign ld_val     = (idx_adv >>> 1) - HALF_HI_S;
    assign frame_busy = (state != ST_IDLE);

    pfs_slot_ctr #(.IW(IW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (sample_vld),
        .clr     (end_data),
        .ld      (go_sync2 && mode_baud_hi),
        .spb     (spb_cur),
        .ld_val  (ld_val),
        .idx_q   (idx_q),
        .idx_adv (idx_adv)
    );

    pfs_centre_calc #(.IW(IW)) u_centre (
        .first_slot (start_q),
        .last_slot  (idx_adv),
        .spb        (spb_cur),
        .centre     (centre_w)
    );

    // Frame state machine with its counters and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            start_q      <= '0;
            centre_q     <= '0;
            count_q      <= '0;
            fiw_sr       <= '0;
            fiw_word     <= '0;
            fiw_valid    <= 1'b0;
            data_strobe  <= 1'b0;
            data_symbol  <= '0;
            frame_end    <= 1'b0;
            cur_baud_hi  <= 1'b0;
            cur_four_lvl <= 1'b0;
        end else begin
            fiw_valid   <= 1'b0;
            data_strobe <= 1'b0;
            frame_end   <= 1'b0;
            if (sample_vld) begin
                unique case (state)
                    ST_IDLE: if (sync_hit) begin
                        state   <= ST_SYNCING;
                        start_q <= idx_adv;
                    end
                    ST_SYNCING: if (!sync_hit) begin
                        state    <= ST_SYNC1;
                        centre_q <= centre_w;
                        count_q  <= '0;
                    end
                    ST_SYNC1: if (at_centre) begin
                        fiw_sr  <= {fiw_sr[FIW_W-2:0], new_bit};
                        count_q <= cnt_inc;
                        if (go_sync2) begin
                            state        <= ST_SYNC2;
                            fiw_word     <= {fiw_sr[FIW_W-2:0], new_bit};
                            fiw_valid    <= 1'b1;
                            cur_baud_hi  <= mode_baud_hi;
                            cur_four_lvl <= mode_four_lvl;
                            count_q      <= mode_baud_hi ? MINUS_ONE : '0;
                            centre_q     <= mode_baud_hi ? (centre_q >>> 1) : centre_q;
                        end
                    end
                    ST_SYNC2: if (at_centre) begin
                        count_q <= cnt_inc;
                        if (cnt_inc == gap_lim) begin
                            state   <= ST_DATA;
                            count_q <= '0;
                        end
                    end
                    ST_DATA: if (at_centre) begin
                        data_strobe <= 1'b1;
                        data_symbol <= rx_symbol;
                        count_q     <= cnt_inc;
                        if (end_data) begin
                            state        <= ST_IDLE;
                            frame_end    <= 1'b1;
                            cur_baud_hi  <= 1'b0;
                            cur_four_lvl <= 1'b0;
                            count_q      <= '0;
                            start_q      <= '0;
                            centre_q     <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R5
    fiw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiw_valid |-> (state == ST_SYNC2) && !data_strobe);

    // R6
    centre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |-> (centre_q >= 0) && (centre_q < spb_cur));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) && ($past(state) == ST_DATA) |-> $stable(cur_baud_hi) && $stable(cur_four_lvl));

    // R8
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe |-> ($past(state) == ST_DATA));

    // R9
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (state == ST_IDLE) && !cur_baud_hi && !cur_four_lvl && data_strobe);
endmodule

// File: tb/pager_frame_seq_tb.sv
module pager_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_vld, sync_hit, mode_baud_hi, mode_four_lvl;
    logic [1:0]  rx_symbol;
    logic        frame_busy, cur_baud_hi, cur_four_lvl;
    logic [31:0] fiw_word;
    logic        fiw_valid, data_strobe, frame_end;
    logic [1:0]  data_symbol;

    always #10 clk = ~clk;

    pager_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .rx_symbol(rx_symbol),
        .sync_hit(sync_hit), .mode_baud_hi(mode_baud_hi), .mode_four_lvl(mode_four_lvl),
        .frame_busy(frame_busy), .cur_baud_hi(cur_baud_hi), .cur_four_lvl(cur_four_lvl),
        .fiw_word(fiw_word), .fiw_valid(fiw_valid), .data_strobe(data_strobe),
        .data_symbol(data_symbol), .frame_end(frame_end)
    );

    typedef struct { int kind; logic [31:0] val; } exp_t;   // kind 0 fiw, 1 data, 2 end
    exp_t exp_q[$];
    int checks = 0, errors = 0;
    bit finished = 0;
    int iq = 0;
    bit stall_on = 0;
    int stall_ctr = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] val);
        exp_t e;
        e.kind = kind; e.val = val;
        exp_q.push_back(e);
    endtask

    // One input sample, optionally preceded by a stall cycle (R2)
    task automatic drive(input logic [1:0] s, input logic sy);
        if (stall_on) begin
            stall_ctr++;
            if (stall_ctr % 3 == 0) begin
                @(negedge clk);
                sample_vld = 1'b0;
                rx_symbol  = ~s;
                sync_hit   = 1'b1;
            end
        end
        @(negedge clk);
        sample_vld = 1'b1;
        rx_symbol  = s;
        sync_hit   = sy;
    endtask

    // Scoreboard monitor: compares every output pulse against the queue
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (fiw_valid) begin
                if (exp_q.size() == 0 || exp_q[0].kind != 0) check(0, "R5 unexpected fiw_valid", fiw_word, 0);
                else begin check(fiw_word == exp_q[0].val, "R5 fiw_word", fiw_word, exp_q[0].val); void'(exp_q.pop_front()); end
            end
            if (data_strobe) begin
                if (exp_q.size() == 0 || exp_q[0].kind != 1) check(0, "R8 unexpected data_strobe", {30'd0, data_symbol}, 0);
                else begin check(data_symbol == exp_q[0].val[1:0], "R8 data_symbol", {30'd0, data_symbol}, exp_q[0].val); void'(exp_q.pop_front()); end
            end
            if (frame_end) begin
                if (exp_q.size() == 0 || exp_q[0].kind != 2) check(0, "R9 unexpected frame_end", 1, 0);
                else begin
                    void'(exp_q.pop_front());
                    check(!frame_busy && !cur_baud_hi && !cur_four_lvl, "R9 idle and mode reset at end",
                          {29'd0, frame_busy, cur_baud_hi, cur_four_lvl}, 0);
                end
            end
        end
    end

    function automatic int centre_of(input int s, input int e);
        if (s < e) return (s + e) / 2;
        return ((s + e) / 2 + 5) % 10;
    endfunction

    task automatic run_frame(input int s_slot, input int len, input bit hi, input bit four,
                             input logic [31:0] word, input int seed);
        int q, c, spb, hits, g, glim, dlim, k, bitv;
        logic [1:0] sym;
        q = iq; spb = 10;
        mode_baud_hi = hi; mode_four_lvl = four;
        // R3: idle up to the chosen start slot, then a sync run
        while ((q + 1) % 10 != s_slot) begin drive(2'd0, 1'b0); q = (q + 1) % 10; end
        for (int i = 0; i < len; i++) begin drive(2'd1, 1'b1); q = (q + 1) % 10; end
        drive(2'd0, 1'b0); q = (q + 1) % 10;
        c = centre_of(s_slot, q);
        @(negedge clk);
        sample_vld = 1'b0;
        check(frame_busy, "R3 busy after sync run", {31'd0, frame_busy}, 1);
        // R4: 16 dotting bits then the word, junk and sync off the centre
        hits = 0;
        while (hits < 48) begin
            q = (q + 1 == spb) ? 0 : q + 1;
            bitv = (hits < 16) ? (hits % 2) : int'(word[31 - (hits - 16)]);
            if (q == c) begin
                sym = bitv ? {1'b1, hits[0]} : {1'b0, hits[0]};
                hits++;
                if (hits == 48) push(0, word);
                drive(sym, 1'b0);
            end else
                drive(bitv ? 2'd1 : 2'd2, q[0]);
        end
        // R6: grid rescale at 3200 baud
        if (hi) begin q = q / 2 - 2; c = c / 2; spb = 5; g = -1; glim = 80; dlim = 5632; end
        else begin g = 0; glim = 40; dlim = 2816; end
        // R7: gap
        while (g < glim) begin
            q = (q + 1 == spb) ? 0 : q + 1;
            if (q == c) g++;
            drive(2'd3, 1'b0);
        end
        // R8: data portion, mode inputs flipped midway
        k = 0;
        while (k < dlim) begin
            q = (q + 1 == spb) ? 0 : q + 1;
            sym = 2'((k * 5 + k / 7 + seed) % 4);
            if (k == 100) begin mode_baud_hi = ~hi; mode_four_lvl = ~four; end
            if (k == 200)
                check(cur_baud_hi == hi && cur_four_lvl == four, "R6 mode latched during data",
                      {30'd0, cur_baud_hi, cur_four_lvl}, {30'd0, hi, four});
            if (q == c) begin
                k++;
                push(1, {30'd0, sym});
                if (k == dlim) push(2, 0);
                drive(sym, k == dlim);   // R9: sync on the final sample is ignored
            end else
                drive(~sym, 1'b0);
        end
        // R9: slot restarts at 0, block stays idle
        q = 0;
        for (int i = 0; i < 3; i++) begin drive(2'd0, 1'b0); q = (q + 1) % 10; end
        @(negedge clk);
        sample_vld = 1'b0;
        check(!frame_busy, "R9 stays idle after frame", {31'd0, frame_busy}, 0);
        check(exp_q.size() == 0, "R8 strobe count per frame", exp_q.size(), 0);
        iq = q;
    endtask

    initial begin
        rst_n = 1'b0; sample_vld = 1'b0; sync_hit = 1'b0; rx_symbol = '0;
        mode_baud_hi = 1'b0; mode_four_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!frame_busy && !fiw_valid && !data_strobe && !frame_end && !cur_baud_hi && !cur_four_lvl,
              "R1 reset state", {26'd0, frame_busy, fiw_valid, data_strobe, frame_end, cur_baud_hi, cur_four_lvl}, 0);
        iq = 1;   // one idle sample consumed below
        sample_vld = 1'b1; rx_symbol = 2'd0; sync_hit = 1'b0;
        // frame 1: 1600 baud, 2 levels, start 3 stop 9, centre 6
        run_frame(3, 6, 1'b0, 1'b0, 32'hC3A5_0F96, 1);
        // frame 2: 3200 baud, 4 levels, start 7 stop 3, centre wraps to 0
        run_frame(7, 6, 1'b1, 1'b1, 32'h5E21_B4D7, 2);
        // frame 3: 1600 baud, 4 levels, stall cycles, start 9 stop 3, centre 1 (R2)
        stall_on = 1;
        run_frame(9, 4, 1'b0, 1'b1, 32'h8001_7FFE, 3);
        stall_on = 0;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule